// File: doc/BRIEF.md
# Ethernet MAC control register file

This block is the 32-bit control and status register bank that sits in front of an Ethernet MAC and its DMA engine. Software reaches it over a simple bus of valid, write, byte address and data. The bank spans an 8 KiB window: the MAC registers sit at the bottom and the DMA registers start at byte offset 0x1000. Read data is returned combinationally in the same cycle as the read request. The bank itself decides which registers hold values, which return fixed identification values, and which can only be written.

Identification and counter registers return fixed values and discard writes. The two poll-demand strobes can only be written. Unmapped and misaligned offsets read as zero. A software reset bit in the DMA bus mode register puts every storage register back to its power-on value, and that bit then reads back as zero. The first station address pair drives a 48-bit address output that the receive path uses. The other three pairs are plain storage. A one-cycle error pulse flags each write to a read-only register and each read of a write-only one.

Top module: `emac_csr_bank`

## Requirements
- R1: After `rst`, reads return the power-on values: timer control (0x034) 0x03E80000, station address 0 high (0x040) 0x8000FFFF, station address 1–3 high (0x048, 0x050, 0x058) 0x0000FFFF, every station address low (0x044, 0x04C, 0x054, 0x05C) 0xFFFFFFFF, DMA bus mode (0x1000) 0x00020100, and every other storage register 0.
- R2: A write with `req_valid` and `req_write` high stores all 32 bits of `req_wdata` into an aligned storage register on the clock edge. A later read at that offset returns the value in the same cycle as the request. `rsp_rdata` is zero whenever no read is requested.
- R3: A write to DMA bus mode (0x1000) with bit 0 set does not store the written value. On that edge, every storage register reloads its R1 value, and bit 0 of bus mode reads 0 afterwards.
- R4: Read-only offsets return fixed values: version (0x020) 0x00001032, hardware feature (0x1058) 0x100D4F37, and interrupt status (0x038), RGMII status (0x0D8), missed-frame counter (0x1020) and the four current-descriptor/buffer registers (0x1048–0x1054) 0. Writes to these offsets change nothing.
- R5: The transmit and receive poll-demand offsets (0x1004, 0x1008) are write-only. Reading them returns 0, and a value written to them cannot be read back anywhere.
- R6: `access_err` is high for exactly the cycle after each write to an R4 offset and each read of an R5 offset, including back-to-back offenders. It is low after every other access.
- R7: `station_mac[47:40]` = bits 15:8 of 0x040, `[39:32]` = bits 7:0 of 0x040, `[31:0]` = 0x044 with its most significant byte in `[31:24]`. The output follows a write on the next clock edge.
- R8: Station addresses 1–3 (0x048–0x05C) store and read back their values, but they never change `station_mac`.
- R9: Unmapped offsets and any address with bits 1:0 non-zero read 0, ignore writes, and never raise `access_err`.
- R10: Write data presented while `req_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset inside the 8 KiB window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle as the read request |
| access_err | output | 1 | One-cycle pulse after an illegal-direction access |
| station_mac | output | 48 | Station address 0, byte 0 in the top byte |

## Verification
A corrupt storage register would show up on the very next read of its offset, because reads are combinational. A wrong station address slot would change `station_mac` one edge after the offending write. A soft reset that misses a register is exposed by reading every class of register back (timer, both station address kinds, bus mode and a plain register) right after the reload. A decode fault that sends a write to the wrong slot is caught either by a read-back mismatch or by a station address output that moves when it should hold. Error pulse faults are visible one cycle after the access, and back-to-back offenders check that each access produces its own pulse.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;

    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 32;
    localparam int MAC_W   = 48;

    // storage register slots
    localparam int SLOT_CFG       = 0;
    localparam int SLOT_FILTER    = 1;
    localparam int SLOT_HASH_HI   = 2;
    localparam int SLOT_HASH_LO   = 3;
    localparam int SLOT_MDIO_ADR  = 4;
    localparam int SLOT_MDIO_DAT  = 5;
    localparam int SLOT_FLOW      = 6;
    localparam int SLOT_VLAN      = 7;
    localparam int SLOT_WAKE      = 8;
    localparam int SLOT_PMT       = 9;
    localparam int SLOT_LPI       = 10;
    localparam int SLOT_TIMER     = 11;
    localparam int SLOT_INT_MASK  = 12;
    localparam int SLOT_STA_BASE  = 13;
    localparam int STA_PAIRS      = 4;
    localparam int STA_REGS       = 2 * STA_PAIRS;
    localparam int SLOT_WDOG      = SLOT_STA_BASE + STA_REGS;
    localparam int SLOT_BUSMODE   = SLOT_WDOG + 1;
    localparam int SLOT_RX_BASE   = SLOT_BUSMODE + 1;
    localparam int SLOT_TX_BASE   = SLOT_BUSMODE + 2;
    localparam int SLOT_DSTATUS   = SLOT_BUSMODE + 3;
    localparam int SLOT_DCTRL     = SLOT_BUSMODE + 4;
    localparam int SLOT_IRQ_EN    = SLOT_BUSMODE + 5;
    localparam int NUM_RW         = SLOT_IRQ_EN + 1;
    localparam int SLOT_W         = $clog2(NUM_RW);

    localparam logic [ADDR_W-1:0] OFF_STA_FIRST = 13'h0040;
    localparam logic [ADDR_W-1:0] OFF_STA_LAST  = OFF_STA_FIRST + ADDR_W'(4 * (STA_REGS - 1));
    localparam logic [ADDR_W-1:0] OFF_BUSMODE   = 13'h1000;

    localparam logic [DATA_W-1:0] SWR_MASK = 32'h0000_0001;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_RW   = 2'd1,
        K_RO   = 2'd2,
        K_WO   = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e           kind;
        logic [SLOT_W-1:0]   slot;
        logic [DATA_W-1:0]   fixed;
    } reg_info_t;

    function automatic reg_info_t as_rw(input int n);
        reg_info_t r;
        r.kind  = K_RW;
        r.slot  = SLOT_W'(n);
        r.fixed = '0;
        return r;
    endfunction

    function automatic reg_info_t as_ro(input logic [DATA_W-1:0] v);
        reg_info_t r;
        r.kind  = K_RO;
        r.slot  = '0;
        r.fixed = v;
        return r;
    endfunction

    function automatic reg_info_t lookup(input logic [ADDR_W-1:0] off);
        reg_info_t r;
        r.kind  = K_NONE;
        r.slot  = '0;
        r.fixed = '0;
        if (off[1:0] != 2'b00) begin
            return r;
        end
        if (off >= OFF_STA_FIRST && off <= OFF_STA_LAST) begin
            return as_rw(SLOT_STA_BASE + int'((off - OFF_STA_FIRST) >> 2));
        end
        case (off)
            13'h0000: r = as_rw(SLOT_CFG);
            13'h0004: r = as_rw(SLOT_FILTER);
            13'h0008: r = as_rw(SLOT_HASH_HI);
            13'h000C: r = as_rw(SLOT_HASH_LO);
            13'h0010: r = as_rw(SLOT_MDIO_ADR);
            13'h0014: r = as_rw(SLOT_MDIO_DAT);
            13'h0018: r = as_rw(SLOT_FLOW);
            13'h001C: r = as_rw(SLOT_VLAN);
            13'h0020: r = as_ro(32'h0000_1032);
            13'h0028: r = as_rw(SLOT_WAKE);
            13'h002C: r = as_rw(SLOT_PMT);
            13'h0030: r = as_rw(SLOT_LPI);
            13'h0034: r = as_rw(SLOT_TIMER);
            13'h0038: r = as_ro('0);
            13'h003C: r = as_rw(SLOT_INT_MASK);
            13'h00D8: r = as_ro('0);
            13'h00DC: r = as_rw(SLOT_WDOG);
            13'h1000: r = as_rw(SLOT_BUSMODE);
            13'h1004: r.kind = K_WO;
            13'h1008: r.kind = K_WO;
            13'h100C: r = as_rw(SLOT_RX_BASE);
            13'h1010: r = as_rw(SLOT_TX_BASE);
            13'h1014: r = as_rw(SLOT_DSTATUS);
            13'h1018: r = as_rw(SLOT_DCTRL);
            13'h101C: r = as_rw(SLOT_IRQ_EN);
            13'h1020: r = as_ro('0);
            13'h1048: r = as_ro('0);
            13'h104C: r = as_ro('0);
            13'h1050: r = as_ro('0);
            13'h1054: r = as_ro('0);
            13'h1058: r = as_ro(32'h100D_4F37);
            default:  r.kind = K_NONE;
        endcase
        return r;
    endfunction

    // power-on table entry of a storage slot
    function automatic logic [DATA_W-1:0] cold_value(input int s);
        if (s == SLOT_TIMER)   return 32'h03E8_0000;
        if (s == SLOT_BUSMODE) return 32'h0002_0101;
        if (s >= SLOT_STA_BASE && s < SLOT_STA_BASE + STA_REGS) begin
            if (((s - SLOT_STA_BASE) % 2) == 1) return 32'hFFFF_FFFF;
            if (s == SLOT_STA_BASE)             return 32'h8000_FFFF;
            return 32'h0000_FFFF;
        end
        return '0;
    endfunction

    // value loaded at reset: the table entry with the self-clearing bit dropped
    function automatic logic [DATA_W-1:0] reload_value(input int s);
        if (s == SLOT_BUSMODE) return cold_value(s) & ~SWR_MASK;
        return cold_value(s);
    endfunction

endpackage

// File: rtl/emac_csr_decode.sv
module emac_csr_decode
    import emac_csr_pkg::*;
(
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                swr_bit,
    output reg_info_t           info,
    output logic [NUM_RW-1:0]   wr_en,
    output logic                soft_rst,
    output logic                bad_access
);

    logic wr_hit;

    always_comb begin
        info = lookup(req_addr);
    end

    assign wr_hit   = req_valid && req_write && (info.kind == K_RW);
    assign soft_rst = wr_hit && (info.slot == SLOT_W'(SLOT_BUSMODE)) && swr_bit;

    generate
        for (genvar i = 0; i < NUM_RW; i++) begin : g_we
            assign wr_en[i] = wr_hit && (info.slot == SLOT_W'(i));
        end
    endgenerate

    assign bad_access = req_valid &&
                        (( req_write && (info.kind == K_RO)) ||
                         (!req_write && (info.kind == K_WO)));

endmodule

// File: rtl/emac_csr_store.sv
module emac_csr_store
    import emac_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reload,
    input  logic [NUM_RW-1:0]   wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   q [NUM_RW]
);

    generate
        for (genvar i = 0; i < NUM_RW; i++) begin : g_slot
            localparam logic [DATA_W-1:0] INIT = reload_value(i);

            always_ff @(posedge clk) begin
                if (rst || reload) begin
                    q[i] <= INIT;
                end else if (wr_en[i]) begin
                    q[i] <= wdata;
                end
            end

            // R2: a slot not addressed keeps its contents
            a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
                (!wr_en[i] && !reload) |=> $stable(q[i]));

            // R3: reload lands on the power-on value
            a_r3_reload_cold: assert property (@(posedge clk) disable iff (rst)
                reload |=> (q[i] == INIT));
        end
    endgenerate

endmodule

// File: rtl/emac_station_addr.sv
module emac_station_addr
    import emac_csr_pkg::*;
(
    input  logic [15:0]        hi_word,
    input  logic [DATA_W-1:0]  lo_word,
    output logic [MAC_W-1:0]   mac
);

    localparam int NBYTES = MAC_W / 8;
    logic [7:0] byte_q [NBYTES];

    assign byte_q[0] = hi_word[15:8];
    assign byte_q[1] = hi_word[7:0];

    generate
        for (genvar b = 2; b < NBYTES; b++) begin : g_lo
            assign byte_q[b] = lo_word[DATA_W - 1 - 8*(b-2) -: 8];
        end
        for (genvar b = 0; b < NBYTES; b++) begin : g_pack
            assign mac[MAC_W - 1 - 8*b -: 8] = byte_q[b];
        end
    endgenerate

endmodule

// File: rtl/emac_csr_bank.sv
module emac_csr_bank
    import emac_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                access_err,
    output logic [MAC_W-1:0]    station_mac
);

    reg_info_t           info;
    logic [NUM_RW-1:0]   wr_en;
    logic                soft_rst;
    logic                bad_access;
    logic [DATA_W-1:0]   q [NUM_RW];
    logic                rd_req;

    emac_csr_decode u_dec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .swr_bit    (req_wdata[0]),
        .info       (info),
        .wr_en      (wr_en),
        .soft_rst   (soft_rst),
        .bad_access (bad_access)
    );

    emac_csr_store u_store (
        .clk    (clk),
        .rst    (rst),
        .reload (soft_rst),
        .wr_en  (wr_en),
        .wdata  (req_wdata),
        .q      (q)
    );

    emac_station_addr u_sta (
        .hi_word (q[SLOT_STA_BASE][15:0]),
        .lo_word (q[SLOT_STA_BASE + 1]),
        .mac     (station_mac)
    );

    assign rd_req = req_valid && !req_write;

    always_comb begin
        rsp_rdata = '0;
        if (rd_req) begin
            case (info.kind)
                K_RW: if (int'(info.slot) < NUM_RW) rsp_rdata = q[info.slot];
                K_RO: rsp_rdata = info.fixed;
                default: rsp_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            access_err <= 1'b0;
        end else begin
            access_err <= bad_access;
        end
    end

    // R5: write-only offsets read as zero
    a_r5_wo_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && info.kind == K_WO) |-> (rsp_rdata == '0));

    // R4: version register is fixed
    a_r4_version_fixed: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_addr == 13'h0020) |-> (rsp_rdata == 32'h0000_1032));

    // R6: every error pulse has an access behind it
    a_r6_err_has_cause: assert property (@(posedge clk) disable iff (rst)
        access_err |-> $past(req_valid));

    // R8: alternate station addresses never move the output
    a_r8_alias_no_effect: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr >= 13'h0048 && req_addr <= OFF_STA_LAST)
        |=> $stable(station_mac));

    // R9: misaligned accesses stay quiet
    a_r9_unaligned_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[1:0] != 2'b00) |=> !access_err);

    // R10: no request, no change of the address output
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(station_mac));

endmodule

// File: tb/sim_emac_csr_bank.sv
module sim_emac_csr_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        access_err;
    logic [47:0] station_mac;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    emac_csr_bank u0 (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_rdata   (rsp_rdata),
        .access_err  (access_err),
        .station_mac (station_mac)
    );

    // {req number, write, address, data, expected read, expected error}
    localparam int NV = 24;
    localparam logic [82:0] VECS [NV] = '{
        {4'd1, 1'b0, 13'h0034, 32'h0, 32'h03E8_0000, 1'b0},  // R1 timer
        {4'd1, 1'b0, 13'h0040, 32'h0, 32'h8000_FFFF, 1'b0},  // R1 addr0 hi
        {4'd1, 1'b0, 13'h0048, 32'h0, 32'h0000_FFFF, 1'b0},  // R1 addr1 hi
        {4'd1, 1'b0, 13'h005C, 32'h0, 32'hFFFF_FFFF, 1'b0},  // R1 addr3 lo
        {4'd1, 1'b0, 13'h1000, 32'h0, 32'h0002_0100, 1'b0},  // R1 bus mode
        {4'd2, 1'b1, 13'h0004, 32'hA5A5_1234, 32'h0, 1'b0},  // R2 write
        {4'd2, 1'b0, 13'h0004, 32'h0, 32'hA5A5_1234, 1'b0},  // R2 read back
        {4'd4, 1'b1, 13'h0020, 32'h0, 32'h0, 1'b1},          // R4 write RO
        {4'd4, 1'b0, 13'h0020, 32'h0, 32'h0000_1032, 1'b0},  // R4 unchanged
        {4'd4, 1'b0, 13'h1058, 32'h0, 32'h100D_4F37, 1'b0},  // R4 feature
        {4'd4, 1'b1, 13'h1058, 32'hFFFF_FFFF, 32'h0, 1'b1},  // R4 write RO
        {4'd4, 1'b0, 13'h1058, 32'h0, 32'h100D_4F37, 1'b0},  // R4 unchanged
        {4'd5, 1'b0, 13'h1004, 32'h0, 32'h0, 1'b1},          // R5 read WO
        {4'd5, 1'b1, 13'h1008, 32'h0000_1234, 32'h0, 1'b0},  // R5 write WO
        {4'd5, 1'b0, 13'h1008, 32'h0, 32'h0, 1'b1},          // R5 discarded
        {4'd9, 1'b1, 13'h0800, 32'hDEAD_BEEF, 32'h0, 1'b0},  // R9 unmapped
        {4'd9, 1'b0, 13'h0800, 32'h0, 32'h0, 1'b0},          // R9 reads 0
        {4'd9, 1'b1, 13'h0006, 32'h0000_FFFF, 32'h0, 1'b0},  // R9 unaligned
        {4'd9, 1'b0, 13'h0004, 32'h0, 32'hA5A5_1234, 1'b0},  // R9 untouched
        {4'd9, 1'b0, 13'h0005, 32'h0, 32'h0, 1'b0},          // R9 unaligned rd
        {4'd8, 1'b1, 13'h0048, 32'h1234_5678, 32'h0, 1'b0},  // R8 store
        {4'd8, 1'b0, 13'h0048, 32'h0, 32'h1234_5678, 1'b0},  // R8 read back
        {4'd9, 1'b0, 13'h1038, 32'h0, 32'h0, 1'b0},          // R9 gap
        {4'd4, 1'b0, 13'h1048, 32'h0, 32'h0, 1'b0}           // R4 zero RO
    };

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic [12:0] addr, input logic [31:0] data,
                         input logic [31:0] exp, input logic exp_err, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = data;
        #1;
        if (!wr) check({req, " rdata"}, 48'(rsp_rdata), 48'(exp));
        @(posedge clk);
        #1;
        check({req, " err"}, 48'(access_err), 48'(exp_err));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle outputs after reset
        check("R1 err after reset", 48'(access_err), 48'h0);
        check("R1 rdata idle", 48'(rsp_rdata), 48'h0);
        check("R1 R7 mac after reset", station_mac, 48'hFFFF_FFFF_FFFF);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i][78], VECS[i][77:65], VECS[i][64:33], VECS[i][32:1], VECS[i][0],
                  $sformatf("R%0d vec%0d", int'(VECS[i][82:79]), i));
        end

        // R7: byte placement of station address 0
        do_op(1'b1, 13'h0040, 32'h0000_0211, 32'h0, 1'b0, "R7 hi");
        check("R7 mac after hi", station_mac, 48'h0211_FFFF_FFFF);
        do_op(1'b1, 13'h0044, 32'h2233_4455, 32'h0, 1'b0, "R7 lo");
        check("R7 mac after lo", station_mac, 48'h0211_2233_4455);

        // R8: other pairs leave the output alone
        do_op(1'b1, 13'h0050, 32'h0000_ABCD, 32'h0, 1'b0, "R8 wr addr2");
        check("R8 mac unchanged", station_mac, 48'h0211_2233_4455);
        do_op(1'b0, 13'h0050, 32'h0, 32'h0000_ABCD, 1'b0, "R8 rd addr2");

        // R6: back-to-back offenders, then a clean access
        do_op(1'b0, 13'h1004, 32'h0, 32'h0, 1'b1, "R6 first");
        do_op(1'b1, 13'h0038, 32'h1, 32'h0, 1'b1, "R6 second");
        do_op(1'b0, 13'h0034, 32'h0, 32'h03E8_0000, 1'b0, "R6 clean");

        // R10: write data without valid
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b1;
        req_addr  = 13'h0004;
        req_wdata = 32'h0;
        @(posedge clk);
        #1;
        check("R10 no err", 48'(access_err), 48'h0);
        do_op(1'b0, 13'h0004, 32'h0, 32'hA5A5_1234, 1'b0, "R10 unchanged");

        // R2: bus mode without the reset bit stores normally
        do_op(1'b1, 13'h1000, 32'h1234_5670, 32'h0, 1'b0, "R2 busmode wr");
        do_op(1'b0, 13'h1000, 32'h0, 32'h1234_5670, 1'b0, "R2 busmode rd");

        // R3: software reset
        do_op(1'b1, 13'h000C, 32'h0000_0055, 32'h0, 1'b0, "R3 prep");
        do_op(1'b1, 13'h1000, 32'hFFFF_FFFF, 32'h0, 1'b0, "R3 trigger");
        check("R3 mac reloaded", station_mac, 48'hFFFF_FFFF_FFFF);
        do_op(1'b0, 13'h000C, 32'h0, 32'h0, 1'b0, "R3 hash lo");
        do_op(1'b0, 13'h1000, 32'h0, 32'h0002_0100, 1'b0, "R3 busmode");
        do_op(1'b0, 13'h0034, 32'h0, 32'h03E8_0000, 1'b0, "R3 timer");
        do_op(1'b0, 13'h0004, 32'h0, 32'h0, 1'b0, "R3 filter");
        do_op(1'b0, 13'h0050, 32'h0, 32'h0000_FFFF, 1'b0, "R3 addr2 hi");
        do_op(1'b0, 13'h0048, 32'h0, 32'h0000_FFFF, 1'b0, "R3 addr1 hi");
        do_op(1'b0, 13'h0040, 32'h0, 32'h8000_FFFF, 1'b0, "R3 addr0 hi");
        idle();
        #1;
        check("R2 rdata zero when idle", 48'(rsp_rdata), 48'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule